// File: doc/BRIEF.md
# Shared Register-Interface Lock with Owner Identifier

This block provides one exclusive lock that many software threads contend for. They use it to take turns on a shared register interface. Each thread works through its own write channel. Write channel 0 has the highest priority and channel NPORT-1 the lowest. A thread puts a request bit and a 16-bit identifier of its own choosing into a 32-bit word and writes it to the lock address. It then reads the lock word back, and it owns the lock once the identifier field it reads matches its own. When the shared work is done, it writes its identifier again with the request bit clear. A second address clears the lock outright, which recovers from a thread that died while holding it.

The lock is a two-state machine with the states LK_FREE and LK_HELD. It has four named transitions:
- GRANT (LK_FREE to LK_HELD): an acquire arrives while the lock is free.
- RELEASE (LK_HELD to LK_FREE): the owner releases and no acquire arrives in that cycle.
- HANDOFF (LK_HELD to LK_HELD with a new owner): the owner releases and an acquire arrives in the same cycle.
- FORCE_CLEAR (either state to LK_FREE): a write reaches the clear address.

In every other case the state and the owner do not change.

Top module: `owner_lock`

## Requirements
- R1: After reset the lock is free, and a read of the lock address returns 32'h0000_0000.
- R2: A write to the lock address with bit 0 set is an acquire, and bits 31:16 carry the identifier. Bits 15:1 are ignored. When the lock is free, an acquire grants it. A later read then returns the identifier in bits 31:16, zero in bits 15:1, and 1 in bit 0. While the lock is free, the identifier field reads as zero.
- R3: An acquire written while the lock is held leaves the owner and the held bit unchanged. This holds for any identifier, including the owner's own.
- R4: A write to the lock address with bit 0 clear is a release. A release whose identifier equals the owner's frees the lock, and a later read returns 0.
- R5: A release whose identifier differs from the owner's is ignored.
- R6: A write to the clear address frees the lock, whatever its data. It also overrides any acquire or release written in the same cycle.
- R7: When the owner's release and another channel's acquire arrive in the same cycle, the release is applied first, so the lock passes directly to the acquiring identifier.
- R8: When acquires on several channels arrive in the same cycle while the lock is free, the channel with the lowest index wins.
- R9: Read data and rd_valid appear one cycle after rd_en. They show the lock as it stood before any write made in the same cycle as the read. A read of any address other than the lock address returns 0.
- R10: Writes to addresses other than the lock and clear addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | NPORT | Write strobe, one bit per channel |
| wr_addr | input | NPORT*ADDR_W | Write address, channel i at bits [i*ADDR_W +: ADDR_W] |
| wr_data | input | NPORT*32 | Write data, channel i at bits [i*32 +: 32] |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data |

## Verification
The bench builds the block with three write channels, a 4-bit address, the lock at offset 0x0 and the clear at offset 0x8. With three channels it can place an acquire, a release and a clear in the same cycle. That makes the handoff, the lowest-index win among simultaneous acquires, and the dominance of clear all reachable from directed stimulus. Offsets 0x4 and 0xC stay unmapped, so stray reads and writes can be aimed at them.

// File: rtl/owner_lock_pkg.sv
package owner_lock_pkg;
    localparam int WORD_W = 32;
    localparam int ID_W   = 16;
    localparam int ID_LSB = WORD_W - ID_W;

    typedef logic [ID_W-1:0] owner_id_t;

    typedef enum logic {
        LK_FREE = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;

    // Lock word as software sees it: owner in the top half, held flag in bit 0.
    function automatic logic [WORD_W-1:0] pack_word(input logic held, input owner_id_t owner);
        logic [WORD_W-1:0] w;
        w = '0;
        w[WORD_W-1:ID_LSB] = owner;
        w[0] = held;
        return w;
    endfunction
endpackage

// File: rtl/owner_lock_port_dec.sv
module owner_lock_port_dec
    import owner_lock_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] LOCK_OFS = '0,
    parameter logic [ADDR_W-1:0] CLR_OFS  = '0
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] data,
    output logic              acq,
    output logic              rel,
    output logic              clr,
    output owner_id_t         id
);
    logic hit_lock;
    logic unused_low_bits;

    assign hit_lock = en && (addr == LOCK_OFS);
    assign acq      = hit_lock && data[0];
    assign rel      = hit_lock && !data[0];
    assign clr      = en && (addr == CLR_OFS);
    assign id       = data[WORD_W-1:ID_LSB];

    // Bits between the request flag and the identifier carry no meaning.
    assign unused_low_bits = ^data[ID_LSB-1:1];
endmodule

// File: rtl/owner_lock_arb.sv
module owner_lock_arb
    import owner_lock_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  logic [NPORT-1:0]      acq,
    input  logic [NPORT-1:0]      rel,
    input  logic [NPORT-1:0]      clr,
    input  logic [NPORT*ID_W-1:0] ids,
    input  logic                  held,
    input  owner_id_t             owner,
    output logic                  clr_any,
    output logic                  acq_any,
    output owner_id_t             acq_id,
    output logic                  rel_hit
);
    assign clr_any = |clr;
    assign acq_any = |acq;

    // Lowest channel index wins: scan from the top so lower indices overwrite.
    always_comb begin
        acq_id = '0;
        for (int i = NPORT - 1; i >= 0; i--) begin
            if (acq[i]) begin
                acq_id = ids[i*ID_W +: ID_W];
            end
        end
    end

    always_comb begin
        rel_hit = 1'b0;
        for (int i = 0; i < NPORT; i++) begin
            if (rel[i] && held && (ids[i*ID_W +: ID_W] == owner)) begin
                rel_hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/owner_lock_fsm.sv
module owner_lock_fsm
    import owner_lock_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr_any,
    input  logic      acq_any,
    input  owner_id_t acq_id,
    input  logic      rel_hit,
    output logic      held,
    output owner_id_t owner
);
    lock_state_e state_q, state_d;
    owner_id_t   owner_q, owner_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_FREE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    // Transitions: FORCE_CLEAR dominates; then GRANT, RELEASE or HANDOFF.
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        if (clr_any) begin
            state_d = LK_FREE;              // FORCE_CLEAR
            owner_d = '0;
        end else begin
            unique case (state_q)
                LK_FREE: begin
                    if (acq_any) begin
                        state_d = LK_HELD;  // GRANT
                        owner_d = acq_id;
                    end
                end
                LK_HELD: begin
                    if (rel_hit) begin
                        if (acq_any) begin
                            state_d = LK_HELD;  // HANDOFF
                            owner_d = acq_id;
                        end else begin
                            state_d = LK_FREE;  // RELEASE
                            owner_d = '0;
                        end
                    end
                end
                default: begin
                    state_d = LK_FREE;
                    owner_d = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        held  = (state_q == LK_HELD);
        owner = owner_q;
    end
endmodule

// File: rtl/owner_lock_rd.sv
module owner_lock_rd
    import owner_lock_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] LOCK_OFS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              held,
    input  owner_id_t         owner,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= (rd_addr == LOCK_OFS) ? pack_word(held, owner) : '0;
            end
        end
    end
endmodule

// File: rtl/owner_lock.sv
module owner_lock
    import owner_lock_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] LOCK_OFS = 'h0,
    parameter logic [ADDR_W-1:0] CLR_OFS  = 'h8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT-1:0]        wr_en,
    input  logic [NPORT*ADDR_W-1:0] wr_addr,
    input  logic [NPORT*WORD_W-1:0] wr_data,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic                    rd_valid,
    output logic [WORD_W-1:0]       rd_data
);
    logic [NPORT-1:0]      p_acq, p_rel, p_clr;
    logic [NPORT*ID_W-1:0] p_ids;
    logic                  clr_any, acq_any, rel_hit;
    owner_id_t             acq_id;
    logic                  lock_held;
    owner_id_t             lock_owner;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        owner_lock_port_dec #(
            .ADDR_W  (ADDR_W),
            .LOCK_OFS(LOCK_OFS),
            .CLR_OFS (CLR_OFS)
        ) u_dec (
            .en  (wr_en[g]),
            .addr(wr_addr[g*ADDR_W +: ADDR_W]),
            .data(wr_data[g*WORD_W +: WORD_W]),
            .acq (p_acq[g]),
            .rel (p_rel[g]),
            .clr (p_clr[g]),
            .id  (p_ids[g*ID_W +: ID_W])
        );
    end

    owner_lock_arb #(.NPORT(NPORT)) u_arb (
        .acq    (p_acq),
        .rel    (p_rel),
        .clr    (p_clr),
        .ids    (p_ids),
        .held   (lock_held),
        .owner  (lock_owner),
        .clr_any(clr_any),
        .acq_any(acq_any),
        .acq_id (acq_id),
        .rel_hit(rel_hit)
    );

    owner_lock_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_any(clr_any),
        .acq_any(acq_any),
        .acq_id (acq_id),
        .rel_hit(rel_hit),
        .held   (lock_held),
        .owner  (lock_owner)
    );

    owner_lock_rd #(
        .ADDR_W  (ADDR_W),
        .LOCK_OFS(LOCK_OFS)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .held    (lock_held),
        .owner   (lock_owner),
        .rd_valid(rd_valid),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/owner_lock_chk.sv
module owner_lock_chk
    import owner_lock_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] LOCK_OFS = 'h0,
    parameter logic [ADDR_W-1:0] CLR_OFS  = 'h8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NPORT-1:0]        wr_en,
    input logic [NPORT*ADDR_W-1:0] wr_addr,
    input logic [NPORT*WORD_W-1:0] wr_data,
    input logic                    rd_en,
    input logic                    rd_valid,
    input logic [WORD_W-1:0]       rd_data,
    input logic                    lock_held,
    input owner_id_t               lock_owner
);
    logic      c_clr, c_acq, c_rel_own, c_rel_other;
    owner_id_t c_first_id;

    // Events seen directly at the write channels.
    always_comb begin
        c_clr = 1'b0; c_acq = 1'b0; c_rel_own = 1'b0; c_rel_other = 1'b0;
        c_first_id = '0;
        for (int i = NPORT - 1; i >= 0; i--) begin
            if (wr_en[i] && wr_addr[i*ADDR_W +: ADDR_W] == CLR_OFS) c_clr = 1'b1;
            if (wr_en[i] && wr_addr[i*ADDR_W +: ADDR_W] == LOCK_OFS) begin
                if (wr_data[i*WORD_W]) begin
                    c_acq = 1'b1;
                    c_first_id = wr_data[i*WORD_W + ID_LSB +: ID_W];
                end else if (wr_data[i*WORD_W + ID_LSB +: ID_W] == lock_owner) begin
                    c_rel_own = 1'b1;
                end else begin
                    c_rel_other = 1'b1;
                end
            end
        end
    end

    p_free_owner_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_data[0]) |-> (rd_data[WORD_W-1:ID_LSB] == '0));

    p_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_clr && !lock_held && c_acq) |=> (lock_held && lock_owner == $past(c_first_id)));

    p_held_ignores_acq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_clr && lock_held && !c_rel_own) |=> (lock_held && $stable(lock_owner)));

    p_release_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_clr && lock_held && c_rel_own && !c_acq) |=> !lock_held);

    p_foreign_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_clr && lock_held && c_rel_other && !c_rel_own) |=> $stable(lock_owner));

    p_clear_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
        c_clr |=> (!lock_held && lock_owner == '0));

    p_handoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_clr && lock_held && c_rel_own && c_acq) |=> (lock_held && lock_owner == $past(c_first_id)));

    p_read_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
endmodule

bind owner_lock owner_lock_chk #(
    .NPORT   (NPORT),
    .ADDR_W  (ADDR_W),
    .LOCK_OFS(LOCK_OFS),
    .CLR_OFS (CLR_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .lock_held (lock_held),
    .lock_owner(lock_owner)
);

// File: tb/owner_lock_tb_top.sv
module owner_lock_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NPORT  = 3;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] A_LOCK = 4'h0;
    localparam logic [ADDR_W-1:0] A_CLR  = 4'h8;
    localparam logic [ADDR_W-1:0] A_HOLE = 4'h4;
    localparam logic [ADDR_W-1:0] A_HOLE2 = 4'hC;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NPORT-1:0]        wr_en = '0;
    logic [NPORT*ADDR_W-1:0] wr_addr = '0;
    logic [NPORT*32-1:0]     wr_data = '0;
    logic                    rd_en = 1'b0;
    logic [ADDR_W-1:0]       rd_addr = '0;
    logic                    rd_valid;
    logic [31:0]             rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    owner_lock #(
        .NPORT(NPORT), .ADDR_W(ADDR_W), .LOCK_OFS(A_LOCK), .CLR_OFS(A_CLR)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [31:0] acq_w(input logic [15:0] id);
        return {id, 16'h0001};
    endfunction
    function automatic logic [31:0] rel_w(input logic [15:0] id);
        return {id, 16'h0000};
    endfunction

    // Driver: stage a write on one channel (applied on the next edge).
    task automatic put(input int p, input logic [ADDR_W-1:0] a, input logic [31:0] d);
        wr_en[p] = 1'b1;
        wr_addr[p*ADDR_W +: ADDR_W] = a;
        wr_data[p*32 +: 32] = d;
    endtask

    // Driver: stage a read and push its expected word into the scoreboard.
    task automatic rd_req(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
        rd_en = 1'b1;
        rd_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic tick();
        @(negedge clk);
        wr_en = '0;
        rd_en = 1'b0;
    endtask

    task automatic expect_lock(input logic [31:0] e, input string tag);
        rd_req(A_LOCK, e, tag);
        tick();
    endtask

    // Monitor: compares each returned read against the queue head.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R9 unexpected read data: actual %h expected none", rd_data);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    failures++;
                    $display("FAIL %s: actual %h expected %h", t, rd_data, e);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        expect_lock(32'h0000_0000, "R1 reset lock word");
        // R9: unmapped read returns zero
        rd_req(A_HOLE, 32'h0, "R9 unmapped read");
        tick();

        // R2: acquire while free
        put(0, A_LOCK, acq_w(16'hA5A5));
        tick();
        expect_lock(32'hA5A5_0001, "R2 grant to A5A5");

        // R3: acquire by another id while held is ignored
        put(1, A_LOCK, acq_w(16'h1234));
        tick();
        expect_lock(32'hA5A5_0001, "R3 acquire while held");

        // R5: release by a non-owner is ignored
        put(1, A_LOCK, rel_w(16'h1234));
        tick();
        expect_lock(32'hA5A5_0001, "R5 foreign release");

        // R10: writes to unmapped addresses change nothing
        put(0, A_HOLE, rel_w(16'hA5A5));
        put(1, A_HOLE2, 32'hFFFF_FFFF);
        tick();
        expect_lock(32'hA5A5_0001, "R10 unmapped writes");

        // R9: read in the same cycle as the owner's release shows the old word
        put(0, A_LOCK, rel_w(16'hA5A5));
        rd_req(A_LOCK, 32'hA5A5_0001, "R9 read alongside release");
        tick();
        // R4: the owner's release frees the lock
        expect_lock(32'h0000_0000, "R4 owner release");

        // R8: simultaneous acquires, lowest channel index wins
        put(2, A_LOCK, acq_w(16'h0BEE));
        put(1, A_LOCK, acq_w(16'h1234));
        tick();
        expect_lock(32'h1234_0001, "R8 lowest index wins");

        // R7: release and acquire in the same cycle hand the lock over
        put(1, A_LOCK, rel_w(16'h1234));
        put(2, A_LOCK, acq_w(16'h0BEE));
        tick();
        expect_lock(32'h0BEE_0001, "R7 handoff");

        // R6: clear with zero data frees the lock
        put(0, A_CLR, 32'h0);
        tick();
        expect_lock(32'h0000_0000, "R6 clear frees");

        // R6: clear overrides a same-cycle acquire
        put(0, A_LOCK, acq_w(16'h0007));
        put(2, A_CLR, 32'hFFFF_FFFF);
        tick();
        expect_lock(32'h0000_0000, "R6 clear beats acquire");

        // R2: bits 15:1 are ignored on acquire
        put(1, A_LOCK, 32'h4321_00F1);
        tick();
        expect_lock(32'h4321_0001, "R2 middle bits ignored");

        // R3: repeated acquire by the owner keeps the lock
        put(2, A_LOCK, acq_w(16'h4321));
        tick();
        expect_lock(32'h4321_0001, "R3 owner re-acquire");

        // R6: clear with arbitrary data while held
        put(1, A_CLR, 32'h1234_5678);
        tick();
        expect_lock(32'h0000_0000, "R6 clear arbitrary data");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R9 reads left unanswered: actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule